// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block watches the command strobes of a double-data-rate SDRAM interface on every rising clock edge. It turns the chip-select, RAS, CAS and WE levels, together with the auto-precharge address bit, into a decoded command code. It also follows the state of each of eight banks through opening, bursting, write recovery, closing and refresh. Each command is checked against the addressed bank's state, and against the whole device where the command affects every bank. Any command that breaks those rules raises a one-cycle illegal flag.

It is meant to sit beside a memory controller or a device model as a protocol monitor. The command, the illegal flag and the bank states appear one cycle after the edge that sampled the command. All inter-command delays are fixed parameters, counted in clock cycles.

The block has no streaming data path. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: A command is taken only when `cke` is high at the sampling edge and was also high at the edge before. Otherwise `dec_cmd` shows NOP (0) and no bank changes state except through its timers.
- R2: Decoding of (cs_n,ras_n,cas_n,we_n) is as follows. cs_n=1 gives NOP. 0111 gives NOP (0). 0110 gives burst stop (1). 0101 gives read (2/3). 0100 gives write (4/5). 0011 gives activate (6). 0010 gives precharge (7/8). 0001 gives refresh (9). 0000 gives mode set (10). The result appears on `dec_cmd` one cycle after the edge.
- R3: When `ap` is 1, read becomes read-with-auto-precharge (3), write becomes write-with-auto-precharge (5) and precharge becomes precharge-all (8).
- R4: Activate is legal only on an idle bank (state 0). The bank is then opening (1) for T_RCD cycles and open (2) after that.
- R5: Read is legal on an open bank, and on a reading bank (3) without auto-precharge. Write is legal on an open bank, and on a writing (4) or recovering (5) bank without auto-precharge. A read lasts T_BURST cycles and ends in open, or in closing (6) with auto-precharge.
- R6: Mode set and refresh are illegal unless all eight banks are idle. A refresh holds every bank in refreshing (7) for T_RFC cycles.
- R7: Burst stop on a bank that is reading without auto-precharge returns it to open. In every other case it has no effect.
- R8: A write lasts T_BURST cycles and then recovers for T_WR cycles before the bank is open again, or closing with auto-precharge. A read aimed at a writing or recovering bank is illegal.
- R9: Read, write, precharge and activate aimed at an opening bank are illegal.
- R10: An activate is illegal when it comes fewer than T_RRD cycles after the previous accepted activate, on any bank.
- R11: An illegal command sets `illegal` for the one cycle in which `dec_cmd` shows it. The banks then evolve as they would under a NOP.
- R12: Precharge closes an open or reading bank for T_RP cycles, then the bank is idle; on an idle or closing bank it has no effect. Precharge-all does this to every bank and is illegal if any bank is opening, writing, recovering, refreshing or bursting with auto-precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| dec_cmd | output | 4 | Decoded command code (R2) |
| illegal | output | 1 | Illegal command pulse |
| bank_state | output | 24 | Three bits per bank, bank 0 in the low bits |

## Verification
The bench goes after the edges of each timed state, where an off-by-one timer opens a bank a cycle early and lets a read through that should be flagged. It fires commands at banks that are still opening or recovering, and at banks in auto-precharge bursts, where a design with loose checks would accept a precharge-all or a burst stop. It tests back-to-back activates inside the spacing window. It also drops `cke` for single cycles, since a design that does not remember the previous `cke` level would act on the first command after the low cycle.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;
  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_BST  = 4'd1,
    C_RD   = 4'd2,
    C_RDA  = 4'd3,
    C_WR   = 4'd4,
    C_WRA  = 4'd5,
    C_ACT  = 4'd6,
    C_PRE  = 4'd7,
    C_PALL = 4'd8,
    C_REF  = 4'd9,
    C_MRS  = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE    = 3'd0,
    B_OPENING = 3'd1,
    B_OPEN    = 3'd2,
    B_READ    = 3'd3,
    B_WRITE   = 3'd4,
    B_WREC    = 3'd5,
    B_CLOSING = 3'd6,
    B_REFRESH = 3'd7
  } bst_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ap,
  output cmd_e cmd
);
  logic cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  always_comb begin
    cmd = C_NOP;
    if (cke && cke_q && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: cmd = C_NOP;
        3'b110: cmd = C_BST;
        3'b101: cmd = ap ? C_RDA : C_RD;
        3'b100: cmd = ap ? C_WRA : C_WR;
        3'b011: cmd = C_ACT;
        3'b010: cmd = ap ? C_PALL : C_PRE;
        3'b001: cmd = C_REF;
        default: cmd = C_MRS;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_trk_pkg::*;
#(
  parameter int CW      = 4,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 8,
  parameter int T_BURST = 2,
  parameter int T_WR    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  input  logic sel,
  input  logic apply,
  output bst_e state,
  output logic bad
);
  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_RFC = CW'(T_RFC - 1);
  localparam logic [CW-1:0] LD_BL  = CW'(T_BURST - 1);
  localparam logic [CW-1:0] LD_WR  = CW'(T_WR - 1);

  logic [CW-1:0] cnt, cnt_n;
  logic          apf, apf_n;
  bst_e          st_n;
  logic          timed, expired, closable;

  assign timed    = (state != B_IDLE) && (state != B_OPEN);
  assign expired  = timed && (cnt == '0);
  assign closable = (state == B_OPEN) || (state == B_READ && !apf);

  // legality against this bank's own state
  always_comb begin
    bad = 1'b0;
    unique case (cmd)
      C_RD, C_RDA:
        bad = sel && !(state == B_OPEN || (state == B_READ && !apf));
      C_WR, C_WRA:
        bad = sel && !(state == B_OPEN ||
                       ((state == B_WRITE || state == B_WREC) && !apf));
      C_ACT:
        bad = sel && (state != B_IDLE);
      C_PRE:
        bad = sel && !(closable || state == B_IDLE || state == B_CLOSING);
      C_PALL:
        bad = !(closable || state == B_IDLE || state == B_CLOSING);
      C_REF, C_MRS:
        bad = (state != B_IDLE);
      default: bad = 1'b0;
    endcase
  end

  always_comb begin
    st_n  = state;
    cnt_n = (timed && cnt != '0) ? cnt - 1'b1 : cnt;
    apf_n = apf;
    if (expired) begin
      unique case (state)
        B_OPENING: st_n = B_OPEN;
        B_READ: begin
          st_n  = apf ? B_CLOSING : B_OPEN;
          cnt_n = LD_RP;
          apf_n = 1'b0;
        end
        B_WRITE: begin
          st_n  = B_WREC;
          cnt_n = LD_WR;
        end
        B_WREC: begin
          st_n  = apf ? B_CLOSING : B_OPEN;
          cnt_n = LD_RP;
          apf_n = 1'b0;
        end
        default: st_n = B_IDLE;
      endcase
    end
    if (apply) begin
      unique case (cmd)
        C_ACT: if (sel) begin
          st_n  = B_OPENING;
          cnt_n = LD_RCD;
        end
        C_RD, C_RDA: if (sel) begin
          st_n  = B_READ;
          cnt_n = LD_BL;
          apf_n = (cmd == C_RDA);
        end
        C_WR, C_WRA: if (sel) begin
          st_n  = B_WRITE;
          cnt_n = LD_BL;
          apf_n = (cmd == C_WRA);
        end
        C_BST: if (sel && state == B_READ && !apf) begin
          st_n = B_OPEN;
        end
        C_PRE, C_PALL: if ((sel || cmd == C_PALL) && closable) begin
          st_n  = B_CLOSING;
          cnt_n = LD_RP;
        end
        C_REF: begin
          st_n  = B_REFRESH;
          cnt_n = LD_RFC;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= B_IDLE;
      cnt   <= '0;
      apf   <= 1'b0;
    end else begin
      state <= st_n;
      cnt   <= cnt_n;
      apf   <= apf_n;
    end
  end
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int NB      = 8,
  parameter int BAW     = 3,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 8,
  parameter int T_BURST = 2,
  parameter int T_WR    = 2,
  parameter int T_RRD   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BAW-1:0]  ba,
  input  logic            ap,
  output logic [3:0]      dec_cmd,
  output logic            illegal,
  output logic [NB*3-1:0] bank_state
);
  localparam int TMAX = (T_RFC > T_RCD ? T_RFC : T_RCD) + T_RP + T_BURST + T_WR;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(T_RRD + 1);

  cmd_e          cmd;
  logic [NB-1:0] bad;
  logic [RW-1:0] rrd_cnt;
  logic          act_bad, ill_now, apply;

  ddr_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ap(ap), .cmd(cmd)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bst_e st;
    ddr_bank_fsm #(
      .CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
      .T_BURST(T_BURST), .T_WR(T_WR)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd),
      .sel(ba == BAW'(b)), .apply(apply), .state(st), .bad(bad[b])
    );
    assign bank_state[b*3 +: 3] = st;
  end

  assign act_bad = (cmd == C_ACT) && (rrd_cnt != '0);
  assign ill_now = (|bad) || act_bad;
  assign apply   = !ill_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_cnt <= '0;
      dec_cmd <= 4'd0;
      illegal <= 1'b0;
    end else begin
      if (apply && cmd == C_ACT) rrd_cnt <= RW'(T_RRD - 1);
      else if (rrd_cnt != '0)    rrd_cnt <= rrd_cnt - 1'b1;
      dec_cmd <= cmd;
      illegal <= ill_now;
    end
  end
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk #(
  parameter int NB  = 8,
  parameter int BAW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cke,
  input logic [BAW-1:0]  ba,
  input logic [3:0]      dec_cmd,
  input logic            illegal,
  input logic [NB*3-1:0] bank_state
);
  logic [BAW-1:0] ba_q;
  logic           all_idle, all_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ba_q <= '0;
    else        ba_q <= ba;
  end

  always_comb begin
    all_idle = 1'b1;
    all_ref  = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (bank_state[b*3 +: 3] != 3'd0) all_idle = 1'b0;
      if (bank_state[b*3 +: 3] != 3'd7) all_ref  = 1'b0;
    end
  end

  assert_cke_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cke) |-> dec_cmd == 4'd0);

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_cmd == 4'd6 && !illegal) |-> bank_state[ba_q*3 +: 3] == 3'd1);

  assert_ref_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_cmd == 4'd9 && !illegal) |-> all_ref);

  assert_mrs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_cmd == 4'd10 && !illegal) |-> all_idle);

  assert_nop_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_cmd == 4'd0) |-> !illegal);

  for (genvar b = 0; b < NB; b++) begin : g_b
    assert_opening_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state[b*3 +: 3] == 3'd1) |->
        ($past(bank_state[b*3 +: 3]) == 3'd0 || $past(bank_state[b*3 +: 3]) == 3'd1));
  end
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(.NB(NB), .BAW(BAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .ba(ba), .dec_cmd(dec_cmd),
  .illegal(illegal), .bank_state(bank_state)
);

// File: tb/ddr_cmd_tracker_tb.sv
module ddr_cmd_tracker_tb;
  localparam int CLK_P = 10;
  localparam int NB = 8, T_RCD = 3, T_RP = 3, T_RFC = 8, T_BURST = 2, T_WR = 2, T_RRD = 2;

  logic clk = 0, rst_n = 0, cke = 0, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, ap = 0;
  logic [2:0] ba = 0;
  logic [3:0] dec_cmd;
  logic illegal;
  logic [NB*3-1:0] bank_state;

  int tests = 0, fails = 0;
  // bench reference state
  int m_st[NB], m_cnt[NB], m_rrd, e_cmd;
  bit m_ap[NB], m_ckep, e_ill;

  always #(CLK_P/2) clk = ~clk;

  ddr_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap),
    .dec_cmd(dec_cmd), .illegal(illegal), .bank_state(bank_state)
  );

  function automatic string tag_of(int c, bit gated);
    if (gated) return "R1";
    case (c)
      1: return "R7";  2: return "R5";  3: return "R3";  4: return "R8";
      5: return "R3";  6: return "R4";  7: return "R12"; 8: return "R12";
      9: return "R6"; 10: return "R6";  default: return "R2";
    endcase
  endfunction

  function automatic bit bank_bad(int b, int c, int sel);
    int s = m_st[b];
    bit clos = (s == 2) || (s == 3 && !m_ap[b]);
    case (c)
      2, 3: return sel == b && !(s == 2 || (s == 3 && !m_ap[b]));
      4, 5: return sel == b && !(s == 2 || ((s == 4 || s == 5) && !m_ap[b]));
      6: return sel == b && s != 0;
      7: return sel == b && !(clos || s == 0 || s == 6);
      8: return !(clos || s == 0 || s == 6);
      9, 10: return s != 0;
      default: return 0;
    endcase
  endfunction

  task automatic model(int c, int sel);
    bit ill = (c == 6 && m_rrd != 0);
    for (int b = 0; b < NB; b++) ill |= bank_bad(b, c, sel);
    e_ill = ill; e_cmd = c;
    if (!ill && c == 6) m_rrd = T_RRD - 1; else if (m_rrd != 0) m_rrd--;
    for (int b = 0; b < NB; b++) begin
      int s = m_st[b], n = m_st[b], k = m_cnt[b];
      bit a = m_ap[b];
      bit clos = (s == 2) || (s == 3 && !m_ap[b]);
      bit timed = (s != 0 && s != 2);
      if (timed && k != 0) k--;
      else if (timed) begin
        case (s)
          1: n = 2;
          3, 5: begin n = a ? 6 : 2; k = T_RP - 1; a = 0; end
          4: begin n = 5; k = T_WR - 1; end
          default: n = 0;
        endcase
      end
      if (!ill) begin
        if (c == 6 && sel == b) begin n = 1; k = T_RCD - 1; end
        if ((c == 2 || c == 3) && sel == b) begin n = 3; k = T_BURST - 1; a = (c == 3); end
        if ((c == 4 || c == 5) && sel == b) begin n = 4; k = T_BURST - 1; a = (c == 5); end
        if (c == 1 && sel == b && s == 3 && !m_ap[b]) n = 2;
        if ((c == 8 || (c == 7 && sel == b)) && clos) begin n = 6; k = T_RP - 1; end
        if (c == 9) begin n = 7; k = T_RFC - 1; end
      end
      m_st[b] = n; m_cnt[b] = k; m_ap[b] = a;
    end
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle of raw pins, then compare against the reference
  task automatic pins(bit k, bit cs, bit r, bit c, bit w, int b, bit a);
    int ec;
    bit gated;
    logic [NB*3-1:0] est;
    cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = 3'(b); ap = a;
    @(negedge clk);
    gated = !(k && m_ckep);
    m_ckep = k;
    if (gated || cs) ec = 0;
    else case ({r, c, w})
      3'b111: ec = 0; 3'b110: ec = 1; 3'b101: ec = a ? 3 : 2;
      3'b100: ec = a ? 5 : 4; 3'b011: ec = 6; 3'b010: ec = a ? 8 : 7;
      3'b001: ec = 9; default: ec = 10;
    endcase
    model(ec, b);
    for (int i = 0; i < NB; i++) est[i*3 +: 3] = 3'(m_st[i]);
    chk(dec_cmd == 4'(e_cmd) && illegal == e_ill && bank_state == est,
        tag_of(ec, gated && !cs), "cmd/ill/state",
        {dec_cmd, 3'b0, illegal, bank_state}, {4'(e_cmd), 3'b0, e_ill, est});
  endtask

  task automatic issue(int c, int b, bit k = 1);
    logic [2:0] s;
    case (c)
      0: s = 3'b111; 1: s = 3'b110; 2, 3: s = 3'b101; 4, 5: s = 3'b100;
      6: s = 3'b011; 7, 8: s = 3'b010; 9: s = 3'b001; default: s = 3'b000;
    endcase
    pins(k, 1'b0, s[2], s[1], s[0], b, (c == 3 || c == 5 || c == 8));
  endtask

  function automatic int st_of(int b);
    return int'(bank_state[b*3 +: 3]);
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_cnt[b] = 0; m_ap[b] = 0; end
    m_rrd = 0; m_ckep = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(dec_cmd == 0 && !illegal && bank_state == '0, "R2", "reset", bank_state, 0);
    issue(0, 0);
    // directed corners
    issue(6, 0);  chk(st_of(0) == 1 && !illegal, "R4", "act opens", st_of(0), 1);
    issue(6, 1);  chk(illegal == 1, "R10", "act spacing", illegal, 1);
    chk(st_of(1) == 0, "R11", "illegal leaves idle", st_of(1), 0);
    issue(2, 0);  chk(illegal == 1, "R9", "read while opening", illegal, 1);
    issue(0, 0);  chk(st_of(0) == 2, "R4", "open after rcd", st_of(0), 2);
    issue(9, 0);  chk(illegal == 1, "R6", "refresh with open bank", illegal, 1);
    issue(3, 0);  chk(st_of(0) == 3 && dec_cmd == 3, "R3", "read autoprecharge", dec_cmd, 3);
    issue(1, 0);  chk(st_of(0) == 3 && !illegal, "R7", "bst ignored on ap read", st_of(0), 3);
    issue(0, 0);  chk(st_of(0) == 6, "R5", "ap read closes", st_of(0), 6);
    repeat (3) issue(0, 0);
    chk(st_of(0) == 0, "R12", "idle after rp", st_of(0), 0);
    issue(6, 2);  repeat (3) issue(0, 2);
    issue(4, 2);  chk(st_of(2) == 4, "R8", "write starts", st_of(2), 4);
    issue(2, 2);  chk(illegal == 1, "R8", "read in write", illegal, 1);
    issue(0, 2);  chk(st_of(2) == 5, "R8", "recovering", st_of(2), 5);
    issue(4, 2);  chk(!illegal && st_of(2) == 4, "R8", "write in recovery", st_of(2), 4);
    issue(0, 2);  issue(0, 2);
    issue(8, 0);  chk(illegal == 1, "R12", "pall during recovery", illegal, 1);
    issue(0, 2);  chk(st_of(2) == 2, "R8", "open after wr", st_of(2), 2);
    issue(2, 2);  issue(1, 2);
    chk(st_of(2) == 2, "R7", "bst ends read", st_of(2), 2);
    issue(8, 5);  chk(st_of(2) == 6 && dec_cmd == 8, "R12", "pall closes", st_of(2), 6);
    repeat (3) issue(0, 0);
    issue(10, 0); chk(!illegal, "R6", "mrs all idle", illegal, 0);
    issue(9, 0);  chk(bank_state == {NB{3'd7}}, "R6", "refresh all", bank_state, 0);
    issue(6, 3, 0); chk(dec_cmd == 0, "R1", "cke low", dec_cmd, 0);
    issue(6, 3, 1); chk(dec_cmd == 0, "R1", "cke just back", dec_cmd, 0);
    pins(1, 1, 0, 0, 0, 4, 0); chk(dec_cmd == 0, "R2", "deselect", dec_cmd, 0);
    repeat (8) issue(0, 0);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      int b = $urandom_range(0, NB - 1);
      int c;
      if (r < 3) begin
        pins($urandom_range(0, 1), 1, $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 1), b, $urandom_range(0, 1));
        continue;
      end
      if (r < 30) c = 0; else if (r < 50) c = 6; else if (r < 62) c = 2 + $urandom_range(0, 1);
      else if (r < 74) c = 4 + $urandom_range(0, 1); else if (r < 86) c = 7;
      else if (r < 90) c = 1; else if (r < 94) c = 8; else if (r < 97) c = 9; else c = 10;
      issue(c, b, ($urandom_range(0, 99) < 97));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule